// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

A nine-bit first-in first-out buffer whose write port and read port run on unrelated clocks. Storage depth is a power-of-two parameter. Four active-low status outputs report the fill level. Empty and almost-empty are produced in the read clock domain. Full and almost-full are produced in the write clock domain. The two almost thresholds come from offset inputs, which a separate offset register block drives.

The write port has two enables, one active-low and one active-high. The read port has two active-low enables. The active-high write enable has two roles, and the level it holds while reset is asserted picks between them. If it is held high, it stays a second write enable, which suits depth expansion. If it is held low, it becomes a load strobe for the offset registers. While that strobe is low, FIFO reads and writes are suppressed.

Pointers carry a wrap bit and cross between domains as Gray code through two-stage synchronisers. Read data is registered. When a read is requested on an empty buffer, the output keeps the last word that was validly read.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: A word is stored on a rising `wclk` edge only when `wen1_n` is 0, `wen2_ld` is 1 and `full_n` is 1. A write attempt with `wen2_ld` at 0 stores nothing.
- R2: A read happens on a rising `rclk` edge only when `ren1_n` and `ren2_n` are both 0 and `empty_n` is 1. The next unread word then appears on `dout` after that edge. A request with only one read enable low reads nothing.
- R3: `full_n` is 0 when the buffer holds DEPTH unread words. While `full_n` is 0, write attempts are ignored.
- R4: `empty_n` is 0 when no unread word is held. While `empty_n` is 0, read attempts leave `dout` and the buffer contents unchanged.
- R5: Once pointer updates have settled, `aempty_n` is 0 when the unread count is at most `aempty_ofs`, and 1 when the count is `aempty_ofs`+1 or more.
- R6: Once pointer updates have settled, `afull_n` is 0 when the unread count is at least DEPTH−`afull_ofs`, and 1 otherwise.
- R7: While reset is asserted and after it is released, the block shows an empty buffer: `dout` is 0, `empty_n` and `aempty_n` are 0, and `full_n` and `afull_n` are 1.
- R8: If `wen2_ld` is 0 during reset, the block enters load mode. In load mode, `wen2_ld` at 1 allows normal writes gated by `wen1_n` and normal reads. `wen2_ld` at 0 blocks all FIFO writes and reads.
- R9: Words leave the buffer in the order they were stored, with no loss or duplication, under any interleaving of the two clocks.
- R10: After the buffer becomes non-empty, a read issued on the first `rclk` edge after `empty_n` rises puts the first stored word on `dout` on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wen1_n | input | 1 | Active-low write enable |
| wen2_ld | input | 1 | Second write enable, or the offset load strobe in load mode |
| din | input | 9 | Write data |
| ren1_n | input | 1 | Active-low read enable one |
| ren2_n | input | 1 | Active-low read enable two |
| aempty_ofs | input | log2(DEPTH) | Almost-empty offset, driven by the offset register block |
| afull_ofs | input | log2(DEPTH) | Almost-full offset, driven by the offset register block |
| dout | output | 9 | Registered read data |
| empty_n | output | 1 | Low when the buffer is empty (read domain) |
| full_n | output | 1 | Low when the buffer is full (write domain) |
| aempty_n | output | 1 | Low when almost empty (read domain) |
| afull_n | output | 1 | Low when almost full (write domain) |

## Verification
The assertions assume the following about the inputs:
- Both clocks run for at least two cycles after reset is released, so that the role of `wen2_ld` is latched.
- `wen2_ld` holds its reset level through that release.
- In load mode, the load strobe changes only while the read port is idle long enough for its two-stage synchroniser to settle.
- The offset inputs change only while the buffer is quiescent.

The stimulus keeps to these rules. It resets with `wen2_ld` held steady, toggles the strobe and the offsets only between settle waits, and samples the flags only after several cycles of both clocks have passed with no traffic.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int DATA_W = 9;

  typedef enum logic {
    ROLE_LOAD = 1'b0,
    ROLE_WEN2 = 1'b1
  } wen2_role_e;
endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dcf_ptr_sync.sv
module dcf_ptr_sync #(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    bin_out[PW-1] = sync_q[PW-1];
    for (int i = PW-2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ sync_q[i];
  end
endmodule

// File: rtl/dcf_store.sv
module dcf_store #(
  parameter int DW = 9,
  parameter int AW = 5
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic [AW:0]   rbin_s,
  input  logic [AW-1:0] afull_ofs,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full_n,
  output logic          afull_n
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

  logic [PW-1:0] wbin_q, wbin_d, wgray_d, wcnt;
  logic          full_n_d, afull_n_d;

  // wen2_ld high is required in both roles; in load mode a low strobe blocks writes
  assign we = !wen1_n && wen2_ld && full_n;

  always_comb begin
    wbin_d    = we ? wbin_q + 1'b1 : wbin_q;
    wgray_d   = wbin_d ^ (wbin_d >> 1);
    wcnt      = wbin_d - rbin_s;
    full_n_d  = (wcnt != DEPTH_P);
    afull_n_d = (wcnt < (DEPTH_P - {1'b0, afull_ofs}));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
    end else begin
      wbin_q  <= wbin_d;
      wgray   <= wgray_d;
      full_n  <= full_n_d;
      afull_n <= afull_n_d;
    end
  end

  assign waddr = wbin_q[AW-1:0];

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n) |=> $stable(wbin_q));
  assert_gray_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));
  assert_full_within_afull_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n) |-> (!afull_n));
  assert_blocked_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wen2_ld) |=> $stable(wbin_q));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic              wen2_ld,
  input  logic [AW:0]       wbin_s,
  input  logic [AW-1:0]     aempty_ofs,
  input  logic [DATA_W-1:0] rdata,
  output logic [AW-1:0]     raddr,
  output logic [AW:0]       rgray,
  output logic [DATA_W-1:0] dout,
  output logic              empty_n,
  output logic              aempty_n
);
  localparam int PW = AW + 1;

  wen2_role_e    role_q;
  logic [1:0]    strobe_q;
  logic [PW-1:0] rbin_q, rbin_d, rgray_d, rcnt;
  logic          load_block, re, empty_n_d, aempty_n_d;

  // role is captured on every edge while the synchronised reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) role_q <= wen2_ld ? ROLE_WEN2 : ROLE_LOAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 2'b11;
    else        strobe_q <= {strobe_q[0], wen2_ld};
  end

  assign load_block = (role_q == ROLE_LOAD) && !strobe_q[1];
  assign re         = !ren1_n && !ren2_n && empty_n && !load_block;

  always_comb begin
    rbin_d     = re ? rbin_q + 1'b1 : rbin_q;
    rgray_d    = rbin_d ^ (rbin_d >> 1);
    rcnt       = wbin_s - rbin_d;
    empty_n_d  = (rcnt != '0);
    aempty_n_d = (rcnt > {1'b0, aempty_ofs});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q   <= '0;
      rgray    <= '0;
      dout     <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rbin_q   <= rbin_d;
      rgray    <= rgray_d;
      empty_n  <= empty_n_d;
      aempty_n <= aempty_n_d;
      if (re) dout <= rdata;
    end
  end

  assign raddr = rbin_q[AW-1:0];

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n) |=> ($stable(rbin_q) && $stable(dout)));
  assert_empty_within_aempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n) |-> (!aempty_n));
  assert_load_blocks_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_block |=> ($stable(rbin_q) && $stable(dout)));
  assert_single_enable_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ren1_n != ren2_n) |=> $stable(dout));
endmodule

// File: rtl/dual_clock_flag_fifo.sv
module dual_clock_flag_fifo
  import dcf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              wen1_n,
  input  logic              wen2_ld,
  input  logic [DATA_W-1:0] din,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic [AW-1:0]     aempty_ofs,
  input  logic [AW-1:0]     afull_ofs,
  output logic [DATA_W-1:0] dout,
  output logic              empty_n,
  output logic              full_n,
  output logic              aempty_n,
  output logic              afull_n
);
  localparam int PW = AW + 1;

  logic          wrst_n, rrst_n, we;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wbin_s, rbin_s;
  logic [DATA_W-1:0] rdata;

  dcf_rst_sync u_wrst (.clk(wclk), .rst_n(rst_n), .rst_sync_n(wrst_n));
  dcf_rst_sync u_rrst (.clk(rclk), .rst_n(rst_n), .rst_sync_n(rrst_n));

  dcf_ptr_sync #(.PW(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .gray_in(rgray), .bin_out(rbin_s));
  dcf_ptr_sync #(.PW(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .gray_in(wgray), .bin_out(wbin_s));

  dcf_store #(.DW(DATA_W), .AW(AW)) u_store (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(din), .raddr(raddr), .rdata(rdata)
  );

  dcf_wr_ctl #(.AW(AW)) u_wr (
    .clk(wclk), .rst_n(wrst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .rbin_s(rbin_s), .afull_ofs(afull_ofs), .we(we), .waddr(waddr),
    .wgray(wgray), .full_n(full_n), .afull_n(afull_n)
  );

  dcf_rd_ctl #(.AW(AW)) u_rd (
    .clk(rclk), .rst_n(rrst_n), .ren1_n(ren1_n), .ren2_n(ren2_n), .wen2_ld(wen2_ld),
    .wbin_s(wbin_s), .aempty_ofs(aempty_ofs), .rdata(rdata), .raddr(raddr),
    .rgray(rgray), .dout(dout), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  assert_reset_outputs_R7: assert property (@(posedge rclk)
    (!rst_n) |=> (!rst_n) |-> (dout == '0 && !empty_n && !aempty_n));
endmodule

// File: tb/dual_clock_flag_fifo_bench.sv
module dual_clock_flag_fifo_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = CLK_PERIOD + 4;
  localparam int DEPTH = 32;
  localparam int AW = $clog2(DEPTH);

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wen1_n = 1, wen2_ld = 1, ren1_n = 1, ren2_n = 1;
  logic [8:0] din = '0;
  logic [AW-1:0] aempty_ofs = AW'(7), afull_ofs = AW'(7);
  logic [8:0] dout;
  logic empty_n, full_n, aempty_n, afull_n;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [8:0] q[$];
  logic [8:0] last_dout = '0;

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  dual_clock_flag_fifo #(.DEPTH(DEPTH)) u_dual_clock_flag_fifo (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .din(din), .ren1_n(ren1_n), .ren2_n(ren2_n), .aempty_ofs(aempty_ofs),
    .afull_ofs(afull_ofs), .dout(dout), .empty_n(empty_n), .full_n(full_n),
    .aempty_n(aempty_n), .afull_n(afull_n)
  );

  function automatic bit exp_aempty_n(int cnt, int n); return cnt > n; endfunction
  function automatic bit exp_afull_n(int cnt, int m); return cnt < DEPTH - m; endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
  endtask

  task automatic check_flags(input string req);
    int c = q.size();
    check(empty_n == (c != 0), {req, " empty_n"}, empty_n, c != 0);
    check(full_n == (c != DEPTH), {req, " full_n"}, full_n, c != DEPTH);
    check(aempty_n == exp_aempty_n(c, int'(aempty_ofs)), {req, " aempty_n"}, aempty_n,
          exp_aempty_n(c, int'(aempty_ofs)));
    check(afull_n == exp_afull_n(c, int'(afull_ofs)), {req, " afull_n"}, afull_n,
          exp_afull_n(c, int'(afull_ofs)));
  endtask

  task automatic do_reset(input logic role);
    @(negedge wclk);
    wen2_ld = role; wen1_n = 1; ren1_n = 1; ren2_n = 1;
    rst_n = 0;
    repeat (4) @(negedge rclk);
    check(dout == 0 && !empty_n && !aempty_n && full_n && afull_n, "R7 in reset",
          {dout, empty_n, aempty_n, full_n, afull_n}, 3);
    rst_n = 1;
    repeat (4) @(negedge rclk);
    repeat (4) @(negedge wclk);
    wen2_ld = 1;
    q.delete();
    last_dout = '0;
  endtask

  task automatic wr(input logic [8:0] d, input logic en2);
    @(negedge wclk);
    din = d; wen1_n = 0; wen2_ld = en2;
    if (en2 && full_n) q.push_back(d);
    @(negedge wclk);
    wen1_n = 1;
  endtask

  task automatic rd_chk(input string req);
    bit fire;
    @(negedge rclk);
    ren1_n = 0; ren2_n = 0;
    fire = empty_n;
    if (fire) last_dout = q.pop_front();
    @(negedge rclk);
    ren1_n = 1; ren2_n = 1;
    check(dout == last_dout, req, dout, last_dout);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset(1'b1);
    check(dout == 0 && !empty_n && !aempty_n && full_n && afull_n, "R7 after release",
          {dout, empty_n, aempty_n, full_n, afull_n}, 3);

    // R10: first word latency
    wr(9'h1A5, 1'b1);
    while (!empty_n) @(negedge rclk);
    @(negedge rclk);
    ren1_n = 0; ren2_n = 0;
    check(dout == 0, "R10 before read", dout, 0);
    @(negedge rclk);
    ren1_n = 1; ren2_n = 1;
    last_dout = q.pop_front();
    check(dout == 9'h1A5, "R10 first word", dout, 9'h1A5);
    // R4: read on empty holds output
    rd_chk("R4 hold on empty");
    settle();
    check_flags("R4 flags empty");

    // R1: second enable low blocks write
    wr(9'h0F0, 1'b0);
    settle();
    check_flags("R1 blocked write");

    // R2: one read enable only does not read
    wr(9'h033, 1'b1);
    settle();
    @(negedge rclk); ren1_n = 0; ren2_n = 1;
    repeat (3) @(negedge rclk);
    ren1_n = 1;
    settle();
    check(dout == last_dout && empty_n, "R2 single enable", dout, last_dout);
    rd_chk("R2 read");

    // fill with flag checks R5 R6 R3
    for (int c = 1; c <= DEPTH; c++) begin
      wr(9'(c * 7 + 3), 1'b1);
      if (c == 7 || c == 8 || c == DEPTH - 8 || c == DEPTH - 7 || c == DEPTH) begin
        settle();
        check_flags(c <= 8 ? "R5 fill" : (c == DEPTH ? "R3 full" : "R6 fill"));
      end
    end
    wr(9'h1FF, 1'b1);
    settle();
    check_flags("R3 write while full");
    // offsets changed while quiescent
    aempty_ofs = AW'(2); afull_ofs = AW'(4);
    settle();
    check_flags("R6 new offset");
    for (int c = 0; c < DEPTH; c++) rd_chk("R9 drain order");
    rd_chk("R3 extra word absent");
    settle();
    check_flags("R5 drained");
    aempty_ofs = AW'(7); afull_ofs = AW'(7);

    // random concurrent traffic R9
    fork
      begin
        for (int i = 0; i < 1500; i++) begin
          @(negedge wclk);
          din = 9'($urandom);
          wen1_n = !(($urandom % 100) < (i < 750 ? 70 : 20));
          wen2_ld = ($urandom % 8) != 0;
          if (!wen1_n && wen2_ld && full_n) q.push_back(din);
        end
        @(negedge wclk); wen1_n = 1; wen2_ld = 1;
      end
      begin
        bit pend = 0;
        for (int i = 0; i < 1100; i++) begin
          @(negedge rclk);
          if (pend) check(dout == last_dout, "R9 random order", dout, last_dout);
          ren1_n = ($urandom % 100) >= 65;
          ren2_n = ($urandom % 100) >= 85;
          pend = !ren1_n && !ren2_n && empty_n;
          if (pend) last_dout = q.pop_front();
        end
        @(negedge rclk);
        ren1_n = 1; ren2_n = 1;
        if (pend) check(dout == last_dout, "R9 random order", dout, last_dout);
      end
    join
    settle();
    check_flags("R9 after random");
    while (q.size() > 0) rd_chk("R9 final drain");
    settle();
    check_flags("R9 empty at end");

    // R8 load mode
    do_reset(1'b0);
    check(dout == 0, "R7 dout cleared", dout, 0);
    wr(9'h155, 1'b1);
    settle();
    check_flags("R8 write in load mode");
    @(negedge wclk); wen2_ld = 0;
    settle();
    @(negedge wclk); wen1_n = 0; din = 9'h0AA;
    @(negedge wclk); wen1_n = 1;
    @(negedge rclk); ren1_n = 0; ren2_n = 0;
    repeat (4) @(negedge rclk);
    ren1_n = 1; ren2_n = 1;
    settle();
    check(dout == 0, "R8 strobe low blocks read", dout, 0);
    check_flags("R8 strobe low blocks write");
    @(negedge wclk); wen2_ld = 1;
    settle();
    rd_chk("R8 read after strobe high");
    settle();
    check_flags("R8 empty again");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule